// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block sits between a board-level, active-low reset line and a CPU core. It qualifies that reset by counting how long the line stays low. A low pulse shorter than a parameterised number of system clock cycles is discarded. A pulse that lasts long enough is accepted. While an accepted reset is held, the core stays stalled and the block presents the fixed starting values of the stack pointer, the status-register fields and the clock-gear setting.

When the line goes high again, the block reads a start address of three bytes over a simple byte-wide request/ready memory port. It reads the lowest address of the vector area first and places each byte into its lane of the program counter, least significant byte first. In the cycle after the last byte is captured, it raises a one-cycle start pulse and releases the core stall. A new accepted reset at any point abandons a fetch in progress and starts the sequence again.

A separate power-on reset input only sets the flops to a known state. The core is held from power-on until the first accepted reset has completed its fetch.

Top module: `boot_vector_seq`

## Requirements
- R1: A low pulse on rst_ni that is sampled low on fewer than RST_MIN_CYC (default 10) consecutive rising edges is ignored. No memory request is made, no start pulse occurs, core_hold_o stays as it was and pc_o is unchanged.
- R2: When rst_ni is sampled low on RST_MIN_CYC or more consecutive edges, the reset is accepted. A pulse of exactly RST_MIN_CYC cycles counts. While the line stays low after acceptance, core_hold_o is 1 and mem_req_o is 0.
- R3: After release, the block reads addresses FFFF00h, FFFF01h and FFFF02h in that order, one request at a time. mem_addr_o is held stable while mem_req_o is high and mem_rdy_i is low. A byte is transferred on a rising edge where both are high.
- R4: The byte from FFFF00h goes to pc_o[7:0], the byte from FFFF01h to pc_o[15:8] and the byte from FFFF02h to pc_o[23:16].
- R5: start_o is high for exactly one cycle: the cycle after the third byte is transferred. In that cycle pc_o holds the whole vector and core_hold_o is 0.
- R6: After power-on and after every accepted reset, the outputs take these values: sp_o = 000100h, imask_o = 3'b111, mode_o = 1 and bank_o = 3'b000.
- R7: After power-on and after every accepted reset, gear_o = 3'd4. The gear code g selects a system clock of the input clock divided by 2^(g+1), so code 4 means divide-by-16 followed by a fixed divide-by-2, which is divide-by-32.
- R8: If a reset is accepted during a vector fetch, the fetch is abandoned without a start pulse. After the next release the fetch restarts at FFFF00h.
- R9: The low-time count saturates. A reset held low far longer than RST_MIN_CYC still produces exactly one fetch sequence and one start pulse after release.
- R10: A low pulse shorter than RST_MIN_CYC during a fetch does not disturb it. The three reads finish in order and one start pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low, puts flops in a known state |
| rst_ni | input | 1 | External reset request, active low, synchronous to clk_i |
| mem_req_o | output | 1 | Vector byte read request |
| mem_addr_o | output | 24 | Byte address of the current vector read |
| mem_rdata_i | input | 8 | Read data, taken when mem_req_o and mem_rdy_i are both high |
| mem_rdy_i | input | 1 | Read completion |
| pc_o | output | 24 | Program counter assembled from the vector |
| start_o | output | 1 | One-cycle pulse when execution may begin |
| core_hold_o | output | 1 | Stalls the core until the fetch has completed |
| sp_o | output | 24 | Initial system stack pointer |
| imask_o | output | 3 | Initial interrupt mask level |
| mode_o | output | 1 | Initial status mode bit |
| bank_o | output | 3 | Initial register bank select |
| gear_o | output | 3 | Clock-gear code |

## Verification
The bench builds the block with its default parameters: a ten-cycle qualification threshold, 24-bit addresses and byte-wide data, giving three vector reads. With these values, pulses of nine and ten cycles sit on either side of the acceptance boundary. A memory model with a read latency the bench can set stretches each read long enough for a second reset, accepted or too short, to land in the middle of a fetch. Holds of dozens of cycles drive the low-time counter well past its saturation point.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_HELD,
        ST_FETCH,
        ST_RUN
    } bvs_state_e;

endpackage

// File: rtl/bvs_lowtime.sv
module bvs_lowtime #(
    parameter int unsigned RST_MIN_CYC = 10
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic rst_ni,
    output logic qual_o
);
    localparam int unsigned CNT_W = $clog2(RST_MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RST_MIN_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lt_s;

    lt_s lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (rst_ni) begin
            lt_d.cnt = '0;
        end else if (lt_q.cnt != CNT_TOP) begin
            lt_d.cnt = lt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            lt_q <= '0;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign qual_o = (lt_q.cnt == CNT_TOP);

    // R9
    cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        lt_q.cnt <= CNT_TOP);

    // R1
    high_clears_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        rst_ni |=> (lt_q.cnt == '0) && !qual_o);

    // R2
    count_needs_low_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (lt_q.cnt != '0) |-> $past(!rst_ni));

endmodule

// File: rtl/bvs_initregs.sv
module bvs_initregs #(
    parameter int unsigned          SP_W       = 24,
    parameter logic [SP_W-1:0]      SP_INIT    = 'h000100,
    parameter int unsigned          IMASK_W    = 3,
    parameter int unsigned          BANK_W     = 3,
    parameter int unsigned          GEAR_W     = 3,
    parameter logic [GEAR_W-1:0]    GEAR_INIT  = 'd4
) (
    input  logic               clk_i,
    input  logic               por_ni,
    input  logic               qual_i,
    output logic [SP_W-1:0]    sp_o,
    output logic [IMASK_W-1:0] imask_o,
    output logic               mode_o,
    output logic [BANK_W-1:0]  bank_o,
    output logic [GEAR_W-1:0]  gear_o
);
    typedef struct packed {
        logic [SP_W-1:0]    sp;
        logic [IMASK_W-1:0] imask;
        logic               mode;
        logic [BANK_W-1:0]  bank;
        logic [GEAR_W-1:0]  gear;
    } init_s;

    localparam init_s START_VAL = '{
        sp:    SP_INIT,
        imask: {IMASK_W{1'b1}},
        mode:  1'b1,
        bank:  '0,
        gear:  GEAR_INIT
    };

    init_s ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (qual_i) begin
            ir_d = START_VAL;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            ir_q <= START_VAL;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign sp_o    = ir_q.sp;
    assign imask_o = ir_q.imask;
    assign mode_o  = ir_q.mode;
    assign bank_o  = ir_q.bank;
    assign gear_o  = ir_q.gear;

    // R6
    sp_load_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        qual_i |=> (sp_o == SP_INIT) && (imask_o == {IMASK_W{1'b1}}) && mode_o && (bank_o == '0));

    // R7
    gear_load_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        qual_i |=> (gear_o == GEAR_INIT));

endmodule

// File: rtl/bvs_fetch.sv
module bvs_fetch
    import bvs_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 24,
    parameter int unsigned         DATA_W   = 8,
    parameter logic [ADDR_W-1:0]   VEC_BASE = 'hFFFF00
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              rst_ni,
    input  logic              qual_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              start_o,
    output logic              core_hold_o
);
    localparam int unsigned NBYTES = ADDR_W / DATA_W;
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NBYTES - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = VEC_BASE + ADDR_W'(NBYTES - 1);

    typedef struct packed {
        bvs_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] pc;
        logic              start;
    } fetch_s;

    fetch_s fs_d, fs_q;

    always_comb begin
        fs_d       = fs_q;
        fs_d.start = 1'b0;
        case (fs_q.state)
            ST_IDLE: begin
                if (!rst_ni) fs_d.state = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (rst_ni) fs_d.state = ST_IDLE;
            end
            ST_FETCH: begin
                if (mem_rdy_i) begin
                    for (int b = 0; b < NBYTES; b++) begin
                        if (fs_q.idx == IDX_W'(b)) begin
                            fs_d.pc[b*DATA_W +: DATA_W] = mem_rdata_i;
                        end
                    end
                    if (fs_q.idx == IDX_LAST) begin
                        fs_d.state = ST_RUN;
                        fs_d.idx   = '0;
                        fs_d.start = 1'b1;
                    end else begin
                        fs_d.idx = fs_q.idx + 1'b1;
                    end
                end
            end
            default: ;
        endcase
        // an accepted reset overrides whatever the sequence was doing
        if (qual_i) begin
            fs_d.state = rst_ni ? ST_FETCH : ST_HELD;
            fs_d.idx   = '0;
            fs_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            fs_q <= '{state: ST_IDLE, idx: '0, pc: '0, start: 1'b0};
        end else begin
            fs_q <= fs_d;
        end
    end

    assign mem_req_o   = (fs_q.state == ST_FETCH);
    assign mem_addr_o  = VEC_BASE + ADDR_W'(fs_q.idx);
    assign pc_o        = fs_q.pc;
    assign start_o     = fs_q.start;
    assign core_hold_o = (fs_q.state != ST_RUN);

    // R3
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (mem_req_o && !mem_rdy_i && !qual_i) |=> mem_req_o && $stable(mem_addr_o));

    // R3
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (mem_req_o && mem_rdy_i && !qual_i && (mem_addr_o != ADDR_LAST))
            |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + 1'b1));

    // R5
    start_single_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        start_o |=> !start_o);

    // R5
    start_after_last_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        start_o |-> !core_hold_o && $past(mem_req_o && mem_rdy_i && (mem_addr_o == ADDR_LAST)));

    // R2
    held_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (qual_i && !rst_ni) |=> core_hold_o && !mem_req_o && !start_o);

    // R8
    restart_base_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (qual_i && rst_ni) |=> mem_req_o && (mem_addr_o == VEC_BASE));

endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq #(
    parameter int unsigned RST_MIN_CYC = 10,
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned GEAR_W      = 3
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              rst_ni,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              start_o,
    output logic              core_hold_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [2:0]        imask_o,
    output logic              mode_o,
    output logic [2:0]        bank_o,
    output logic [GEAR_W-1:0] gear_o
);
    localparam logic [ADDR_W-1:0] VEC_BASE  = ADDR_W'(24'hFFFF00);
    localparam logic [ADDR_W-1:0] SP_START  = ADDR_W'(24'h000100);
    localparam logic [GEAR_W-1:0] GEAR_D16  = GEAR_W'(4);

    logic qual;

    bvs_lowtime #(
        .RST_MIN_CYC(RST_MIN_CYC)
    ) u_lowtime (
        .clk_i  (clk_i),
        .por_ni (por_ni),
        .rst_ni (rst_ni),
        .qual_o (qual)
    );

    bvs_fetch #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE)
    ) u_fetch (
        .clk_i       (clk_i),
        .por_ni      (por_ni),
        .rst_ni      (rst_ni),
        .qual_i      (qual),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_rdy_i   (mem_rdy_i),
        .pc_o        (pc_o),
        .start_o     (start_o),
        .core_hold_o (core_hold_o)
    );

    bvs_initregs #(
        .SP_W      (ADDR_W),
        .SP_INIT   (SP_START),
        .IMASK_W   (3),
        .BANK_W    (3),
        .GEAR_W    (GEAR_W),
        .GEAR_INIT (GEAR_D16)
    ) u_initregs (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .qual_i  (qual),
        .sp_o    (sp_o),
        .imask_o (imask_o),
        .mode_o  (mode_o),
        .bank_o  (bank_o),
        .gear_o  (gear_o)
    );

endmodule

// File: tb/sim_boot_vector_seq.sv
`timescale 1ns/1ps
module sim_boot_vector_seq;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_rdy = 1'b0;
    logic [23:0] pc;
    logic        start;
    logic        hold;
    logic [23:0] sp;
    logic [2:0]  imask;
    logic        mode;
    logic [2:0]  bank;
    logic [2:0]  gear;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 0;
    int wc = 0;
    int n_start = 0;
    int nlog = 0;
    logic [23:0] alog [0:31];
    logic [7:0]  vec [0:2];
    logic [23:0] start_pc;
    logic        start_hold;

    always #2 clk = ~clk;

    boot_vector_seq u0 (
        .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_rdy_i(mem_rdy), .pc_o(pc), .start_o(start), .core_hold_o(hold),
        .sp_o(sp), .imask_o(imask), .mode_o(mode), .bank_o(bank), .gear_o(gear)
    );

    function automatic logic [7:0] vbyte(input logic [23:0] a);
        if (a >= 24'hFFFF00 && a <= 24'hFFFF02) return vec[a - 24'hFFFF00];
        return 8'hEE;
    endfunction

    // memory model and observers, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (start) begin
            n_start++;
            start_pc   = pc;
            start_hold = hold;
        end
        if (!por_n || !mem_req) begin
            mem_rdy = 1'b0;
            wc = 0;
        end else if (mem_rdy) begin
            mem_rdy = 1'b0;
            wc = 0;
        end else if (wc >= lat) begin
            mem_rdy   = 1'b1;
            mem_rdata = vbyte(mem_addr);
            if (nlog < 32) alog[nlog] = mem_addr;
            nlog++;
        end else begin
            wc++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr_obs();
        nlog = 0;
        n_start = 0;
    endtask

    task automatic pulse_low(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_start(input int limit);
        int k = 0;
        while (n_start == 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        #0.1;
    endtask

    task automatic set_vec(input logic [23:0] v);
        vec[0] = v[7:0];
        vec[1] = v[15:8];
        vec[2] = v[23:16];
    endtask

    task automatic chk_init(input string tag);
        chk({tag, " R6 sp"}, 32'(sp), 32'h000100);
        chk({tag, " R6 imask"}, 32'(imask), 32'h7);
        chk({tag, " R6 mode"}, 32'(mode), 32'h1);
        chk({tag, " R6 bank"}, 32'(bank), 32'h0);
        chk({tag, " R7 gear"}, 32'(gear), 32'h4);
    endtask

    task automatic t_por_state();
        @(negedge clk);
        chk("por R2 hold", 32'(hold), 32'h1);
        chk("por R5 start", 32'(start), 32'h0);
        chk("por R3 req", 32'(mem_req), 32'h0);
        chk_init("por");
    endtask

    task automatic t_exact_pulse();
        clr_obs();
        lat = 0;
        set_vec(24'h563412);
        pulse_low(10);
        wait_start(200);
        chk("exact R2 accepted starts", 32'(n_start), 32'd1);
        chk("exact R4 pc", 32'(start_pc), 32'h563412);
        chk("exact R5 hold low at start", 32'(start_hold), 32'h0);
        chk("exact R5 single pulse", 32'(start), 32'h0);
        chk("exact R3 count", 32'(nlog), 32'd3);
        chk("exact R3 a0", 32'(alog[0]), 32'hFFFF00);
        chk("exact R3 a1", 32'(alog[1]), 32'hFFFF01);
        chk("exact R3 a2", 32'(alog[2]), 32'hFFFF02);
        chk_init("exact");
    endtask

    task automatic t_short_pulse();
        logic [23:0] pc_before;
        pc_before = pc;
        clr_obs();
        pulse_low(9);
        repeat (30) @(negedge clk);
        chk("short R1 no req", 32'(nlog), 32'd0);
        chk("short R1 no start", 32'(n_start), 32'd0);
        chk("short R1 hold", 32'(hold), 32'h0);
        chk("short R1 pc", 32'(pc), 32'(pc_before));
    endtask

    task automatic t_long_hold();
        int bad_req = 0;
        int bad_hold = 0;
        clr_obs();
        lat = 3;
        set_vec(24'hA1B2C3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (12) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mem_req) bad_req++;
            if (!hold) bad_hold++;
        end
        chk("long R2 no req while held", 32'(bad_req), 32'd0);
        chk("long R2 hold while held", 32'(bad_hold), 32'd0);
        chk_init("long");
        rst_n = 1'b1;
        wait_start(300);
        chk("long R9 one start", 32'(n_start), 32'd1);
        chk("long R9 three reads", 32'(nlog), 32'd3);
        chk("long R4 pc", 32'(start_pc), 32'hA1B2C3);
    endtask

    task automatic t_abort();
        int k = 0;
        clr_obs();
        lat = 8;
        set_vec(24'h0F1E2D);
        pulse_low(10);
        while (nlog < 1 && k < 100) begin
            @(negedge clk);
            k++;
        end
        pulse_low(10);
        wait_start(400);
        chk("abort R8 one start", 32'(n_start), 32'd1);
        chk("abort R8 pc", 32'(start_pc), 32'h0F1E2D);
        chk("abort R8 restart a0", 32'(alog[(nlog-3) & 31]), 32'hFFFF00);
        chk("abort R8 restart a2", 32'(alog[(nlog-1) & 31]), 32'hFFFF02);
    endtask

    task automatic t_short_in_fetch();
        int k = 0;
        clr_obs();
        lat = 8;
        set_vec(24'h778899);
        pulse_low(10);
        while (nlog < 1 && k < 100) begin
            @(negedge clk);
            k++;
        end
        pulse_low(5);
        wait_start(400);
        chk("midshort R10 one start", 32'(n_start), 32'd1);
        chk("midshort R10 reads", 32'(nlog), 32'd3);
        chk("midshort R10 a1", 32'(alog[1]), 32'hFFFF01);
        chk("midshort R10 pc", 32'(start_pc), 32'h778899);
    endtask

    initial begin
        vec[0] = 8'h00; vec[1] = 8'h00; vec[2] = 8'h00;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_por_state();
        t_exact_pulse();
        t_short_pulse();
        t_long_hold();
        t_abort();
        t_short_in_fetch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule